// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block moves received Ethernet frames into system memory through a circular list of 16-byte descriptors. Software programs the start address of the list, the byte offset of its last entry and a software pointer. A hardware pointer walks the list. For each frame the engine reads the buffer address from the current descriptor and stores the frame bytes in that buffer. It then writes back the length field and the status fields, moves the hardware pointer on and raises interrupt bits.

Frames arrive as a byte stream with start, end and error markers and a ready handshake. Memory is reached through a single request/acknowledge port with word data and byte enables. A small register port gives software access to the controls. Software keeps its pointer one descriptor ahead of the entry it will read next. The engine never fills the descriptor that pointer names, so a full ring drops incoming frames rather than overwriting unread ones.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset the interrupt status, the ring start, the last-entry offset, the hardware pointer, the software pointer and the capture register all read 0, and no memory request is raised.
- R2: A frame is stored only when DMA-control bit 1 and receive-enable bit 0 are both set at its first byte. Otherwise the frame is consumed from the stream, nothing is written to memory, no interrupt bit is set and the hardware pointer does not move.
- R3: The buffer address is read from descriptor offset 0. Frame byte n is written to buffer byte n, little-endian within each 32-bit word. In the final partial word only the byte lanes that carry frame bytes are enabled.
- R4: Descriptor offset 8 is written with the byte count (including FCS) plus 3 in bits 15:0. Bits 31:16 hold the MAC status: bit 0 when the error flag is set on the last byte, bit 3 when the count is below MIN_FRAME, and bit 4 when the count is above MAX_FRAME. Long frames are still stored in full. The byte at offset 12 is written with 0x01.
- R5: After the write-back the hardware pointer advances by 16. From ring start + last-entry offset it wraps to the ring start. Writing the ring-start register loads the hardware pointer with the new start.
- R6: The engine never fills the descriptor addressed by the software pointer. A frame that starts while the hardware pointer equals the software pointer is dropped and sets interrupt bit 5.
- R7: Each stored frame sets interrupt bit 0. It also sets bit 1 when its MAC status is zero and bit 2 when its MAC status is non-zero. Bits 3 and 4 stay 0.
- R8: Reading register 0 returns the interrupt bits and clears them; a bit set in the same cycle stays set. The same read copies the hardware pointer into the capture register.
- R9: Register map by index: 0 interrupt status, 1 DMA control, 2 receive enable, 3 ring start, 4 last-entry offset, 5 hardware pointer, 6 captured pointer, 7 software pointer. All registers read back their written values.
- R10: A memory request holds its address and direction stable until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (clears interrupt status at index 0) |
| reg_addr | input | 3 | register index |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, combinational from reg_addr |
| rx_valid | input | 1 | stream byte present |
| rx_ready | output | 1 | stream byte taken at this edge |
| rx_data | input | 8 | stream byte |
| rx_sof | input | 1 | first byte of a frame |
| rx_eof | input | 1 | last byte of a frame |
| rx_err | input | 1 | frame check failed, valid with rx_eof |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | byte address, word aligned |
| mem_wdata | output | 32 | write data |
| mem_be | output | 4 | write byte enables |
| mem_ack | input | 1 | access completes at this edge |
| mem_rdata | input | 32 | read data, valid with mem_ack |
| irq | output | 1 | any interrupt status bit set |

## Verification
The bench builds the block with MIN_FRAME at 64 and MAX_FRAME lowered to 100. With these values, short frames, frames of exactly the maximum and over-long frames all stay a few dozen bytes. A four-entry ring with the software pointer kept one slot ahead brings the wrap from the last entry back to the start within six frames. The same ring reaches the full condition, which is held by not advancing the software pointer. Frame lengths that are not a multiple of four exercise the partial last-word byte enables against untouched guard bytes.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int DESC_BYTES = 16;

  // register indices
  localparam logic [2:0] REG_IRQ   = 3'd0;
  localparam logic [2:0] REG_DMA   = 3'd1;
  localparam logic [2:0] REG_MACEN = 3'd2;
  localparam logic [2:0] REG_BASE  = 3'd3;
  localparam logic [2:0] REG_LAST  = 3'd4;
  localparam logic [2:0] REG_HWP   = 3'd5;
  localparam logic [2:0] REG_HOLD  = 3'd6;
  localparam logic [2:0] REG_SWP   = 3'd7;

  // interrupt bit positions
  localparam int IRQ_DONE  = 0;
  localparam int IRQ_GOOD  = 1;
  localparam int IRQ_FERR  = 2;
  localparam int IRQ_EMPTY = 5;
  localparam int IRQ_W     = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_DATA, ST_WORD, ST_WBLEN, ST_WBDMA, ST_DROP
  } rx_state_e;

  // length field written back: bytes including FCS plus a fixed 3
  function automatic logic [15:0] words_field(input logic [15:0] nbytes);
    return nbytes + 16'd3;
  endfunction

  // MAC status: bit0 check error, bit3 short, bit4 long
  function automatic logic [15:0] mac_stat(input logic [15:0] nbytes,
                                           input logic crc_bad,
                                           input int unsigned min_len,
                                           input int unsigned max_len);
    logic [15:0] s;
    s = '0;
    s[0] = crc_bad;
    s[3] = (32'(nbytes) < min_len);
    s[4] = (32'(nbytes) > max_len);
    return s;
  endfunction

  // byte enables for lanes 0..last_lane
  function automatic logic [3:0] lane_mask(input logic [1:0] last_lane);
    logic [3:0] m;
    for (int i = 0; i < 4; i++) m[i] = (2'(i) <= last_lane);
    return m;
  endfunction

endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [AW-1:0]     hw_ptr,
  input  logic [IRQ_W-1:0]  irq_set,
  output logic [AW-1:0]     ring_base,
  output logic [AW-1:0]     ring_last,
  output logic [AW-1:0]     sw_ptr,
  output logic              rx_on,
  output logic              base_wr,
  output logic              int_rd,
  output logic [IRQ_W-1:0]  irq_vec
);

  logic          dma_rx_en;
  logic          mac_rx_en;
  logic [AW-1:0] hold_q;

  assign base_wr = reg_wr && (reg_addr == REG_BASE);
  assign int_rd  = reg_rd && (reg_addr == REG_IRQ);
  assign rx_on   = dma_rx_en & mac_rx_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dma_rx_en <= 1'b0;
      mac_rx_en <= 1'b0;
      ring_base <= '0;
      ring_last <= '0;
      sw_ptr    <= '0;
      hold_q    <= '0;
      irq_vec   <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          REG_DMA:   dma_rx_en <= reg_wdata[1];
          REG_MACEN: mac_rx_en <= reg_wdata[0];
          REG_BASE:  ring_base <= reg_wdata[AW-1:0];
          REG_LAST:  ring_last <= reg_wdata[AW-1:0];
          REG_SWP:   sw_ptr    <= reg_wdata[AW-1:0];
          default:   ;
        endcase
      end
      if (int_rd) hold_q <= hw_ptr;
      irq_vec <= (int_rd ? '0 : irq_vec) | irq_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_IRQ:   reg_rdata[IRQ_W-1:0] = irq_vec;
      REG_DMA:   reg_rdata[1]         = dma_rx_en;
      REG_MACEN: reg_rdata[0]         = mac_rx_en;
      REG_BASE:  reg_rdata[AW-1:0]    = ring_base;
      REG_LAST:  reg_rdata[AW-1:0]    = ring_last;
      REG_HWP:   reg_rdata[AW-1:0]    = hw_ptr;
      REG_HOLD:  reg_rdata[AW-1:0]    = hold_q;
      REG_SWP:   reg_rdata[AW-1:0]    = sw_ptr;
      default:   reg_rdata            = '0;
    endcase
  end

endmodule

// File: rtl/rxr_ring.sv
module rxr_ring
  import rxr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic [AW-1:0] ring_last,
  input  logic [AW-1:0] sw_ptr,
  input  logic          base_wr,
  input  logic [AW-1:0] new_base,
  input  logic          adv,
  output logic [AW-1:0] hw_ptr,
  output logic          ring_full
);

  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p,
                                             input logic [AW-1:0] b,
                                             input logic [AW-1:0] l);
    return (p == b + l) ? b : p + STEP;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       hw_ptr <= '0;
    else if (base_wr) hw_ptr <= new_base;
    else if (adv)     hw_ptr <= ptr_next(hw_ptr, ring_base, ring_last);
  end

  assign ring_full = (hw_ptr == sw_ptr);

endmodule

// File: rtl/rxr_dma.sv
module rxr_dma
  import rxr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 10318
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_on,
  input  logic [AW-1:0]     hw_ptr,
  input  logic              ring_full,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic              rx_err,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  output logic [3:0]        mem_be,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              fetch_go,
  output logic              drop_go,
  output logic              frame_done,
  output logic              drop_active,
  output logic [IRQ_W-1:0]  irq_set
);

  localparam logic [AW-1:0] OFF_LEN = AW'(8);
  localparam logic [AW-1:0] OFF_DMA = AW'(12);
  localparam logic [AW-1:0] WSTEP   = AW'(4);

  rx_state_e     state;
  logic [AW-1:0] cur_desc;
  logic [AW-1:0] buf_addr;
  logic [AW-1:0] woff;
  logic [15:0]   nbytes;
  logic [31:0]   wbuf;
  logic [3:0]    wbe;
  logic          last_q;
  logic          crc_q;
  logic [1:0]    lane;
  logic [15:0]   stat;
  logic          full_drop;

  assign lane = nbytes[1:0];
  assign stat = mac_stat(nbytes, crc_q, MIN_FRAME, MAX_FRAME);

  assign fetch_go    = (state == ST_IDLE) && rx_valid && rx_sof && rx_on && !ring_full;
  assign drop_go     = (state == ST_IDLE) && rx_valid && rx_sof && !(rx_on && !ring_full);
  assign full_drop   = drop_go && rx_on && ring_full;
  assign frame_done  = (state == ST_WBDMA) && mem_ack;
  assign drop_active = (state == ST_DROP);

  always_comb begin
    irq_set            = '0;
    irq_set[IRQ_DONE]  = frame_done;
    irq_set[IRQ_GOOD]  = frame_done && (stat == 16'd0);
    irq_set[IRQ_FERR]  = frame_done && (stat != 16'd0);
    irq_set[IRQ_EMPTY] = full_drop;
  end

  always_comb begin
    case (state)
      ST_IDLE:          rx_ready = rx_valid && !rx_sof;
      ST_DATA, ST_DROP: rx_ready = 1'b1;
      default:          rx_ready = 1'b0;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = '0;
    case (state)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_desc;
      end
      ST_WORD: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_addr + woff;
        mem_wdata = wbuf;
        mem_be    = wbe;
      end
      ST_WBLEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_desc + OFF_LEN;
        mem_wdata = {stat, words_field(nbytes)};
        mem_be    = 4'b1111;
      end
      ST_WBDMA: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_desc + OFF_DMA;
        mem_wdata = 32'h0000_0001;
        mem_be    = 4'b0001;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_desc <= '0;
      buf_addr <= '0;
      woff     <= '0;
      nbytes   <= '0;
      wbuf     <= '0;
      wbe      <= '0;
      last_q   <= 1'b0;
      crc_q    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (fetch_go) begin
            cur_desc <= hw_ptr;
            state    <= ST_FETCH;
          end else if (drop_go) begin
            state <= ST_DROP;
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            buf_addr <= mem_rdata[AW-1:0];
            woff     <= '0;
            nbytes   <= '0;
            crc_q    <= 1'b0;
            state    <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (rx_valid) begin
            wbuf[{lane, 3'b000} +: 8] <= rx_data;
            nbytes <= nbytes + 16'd1;
            if (rx_eof) crc_q <= rx_err;
            if (lane == 2'd3 || rx_eof) begin
              wbe    <= lane_mask(lane);
              last_q <= rx_eof;
              state  <= ST_WORD;
            end
          end
        end
        ST_WORD: begin
          if (mem_ack) begin
            woff  <= woff + WSTEP;
            state <= last_q ? ST_WBLEN : ST_DATA;
          end
        end
        ST_WBLEN: if (mem_ack) state <= ST_WBDMA;
        ST_WBDMA: if (mem_ack) state <= ST_IDLE;
        ST_DROP:  if (rx_valid && rx_eof) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rxr_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 10318
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [7:0]  rx_data,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic        rx_err,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic [3:0]  mem_be,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        irq
);

  // named internal events, observed by the bound checker
  logic [AW-1:0]    hw_ptr;
  logic [AW-1:0]    sw_ptr;
  logic [AW-1:0]    ring_base;
  logic [AW-1:0]    ring_last;
  logic             ring_full;
  logic             rx_on;
  logic             base_wr;
  logic             int_rd;
  logic             fetch_go;
  logic             drop_go;
  logic             frame_done;
  logic             drop_active;
  logic [IRQ_W-1:0] irq_set;
  logic [IRQ_W-1:0] irq_vec;

  rxr_regs #(.AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .hw_ptr    (hw_ptr),
    .irq_set   (irq_set),
    .ring_base (ring_base),
    .ring_last (ring_last),
    .sw_ptr    (sw_ptr),
    .rx_on     (rx_on),
    .base_wr   (base_wr),
    .int_rd    (int_rd),
    .irq_vec   (irq_vec)
  );

  rxr_ring #(.AW(AW)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_base (ring_base),
    .ring_last (ring_last),
    .sw_ptr    (sw_ptr),
    .base_wr   (base_wr),
    .new_base  (reg_wdata[AW-1:0]),
    .adv       (frame_done),
    .hw_ptr    (hw_ptr),
    .ring_full (ring_full)
  );

  rxr_dma #(.AW(AW), .MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME)) u_dma (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_on       (rx_on),
    .hw_ptr      (hw_ptr),
    .ring_full   (ring_full),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_data     (rx_data),
    .rx_sof      (rx_sof),
    .rx_eof      (rx_eof),
    .rx_err      (rx_err),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_be      (mem_be),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .fetch_go    (fetch_go),
    .drop_go     (drop_go),
    .frame_done  (frame_done),
    .drop_active (drop_active),
    .irq_set     (irq_set)
  );

  assign irq = |irq_vec;

endmodule

// File: rtl/rx_ring_engine_chk.sv
module rx_ring_engine_chk
  import rxr_pkg::*;
#(
  parameter int AW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [31:0]      mem_addr,
  input logic [AW-1:0]    hw_ptr,
  input logic [AW-1:0]    sw_ptr,
  input logic [AW-1:0]    ring_base,
  input logic             fetch_go,
  input logic             frame_done,
  input logic             drop_active,
  input logic             int_rd,
  input logic [IRQ_W-1:0] irq_set,
  input logic [IRQ_W-1:0] irq_vec
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10

  AST_NO_FILL_AT_SW: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_go |-> hw_ptr != sw_ptr); // R6

  AST_ADV_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (hw_ptr == $past(ring_base)) || (hw_ptr == $past(hw_ptr) + AW'(DESC_BYTES))); // R5

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    drop_active |-> !mem_req); // R2

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd && (irq_set == '0) |=> irq_vec == '0); // R8

  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> irq_vec[IRQ_DONE]); // R7

  AST_RSVD_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    irq_vec[4:3] == 2'b00); // R7

endmodule

bind rx_ring_engine rx_ring_engine_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req     (mem_req),
  .mem_we      (mem_we),
  .mem_ack     (mem_ack),
  .mem_addr    (mem_addr),
  .hw_ptr      (hw_ptr),
  .sw_ptr      (sw_ptr),
  .ring_base   (ring_base),
  .fetch_go    (fetch_go),
  .frame_done  (frame_done),
  .drop_active (drop_active),
  .int_rd      (int_rd),
  .irq_set     (irq_set),
  .irq_vec     (irq_vec)
);

// File: tb/tb_rx_ring_engine.sv
`timescale 1ns/1ps
module tb_rx_ring_engine;

  localparam int BASE = 32'h100;
  localparam int LAST = 48;
  localparam int NV   = 6;
  // {len[55:40], err[39:32], len_field[31:16], mac_status[15:8], irq[7:0]}
  localparam logic [55:0] VEC [NV] = '{
    {16'd64,  8'd0, 16'd67,  8'h00, 8'h03},
    {16'd70,  8'd1, 16'd73,  8'h01, 8'h05},
    {16'd20,  8'd0, 16'd23,  8'h08, 8'h05},
    {16'd101, 8'd0, 16'd104, 8'h10, 8'h05},
    {16'd65,  8'd0, 16'd68,  8'h00, 8'h03},
    {16'd100, 8'd0, 16'd103, 8'h00, 8'h03}
  };

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic rx_valid = 0, rx_ready, rx_sof = 0, rx_eof = 0, rx_err = 0;
  logic [7:0] rx_data = 0;
  logic mem_req, mem_we, mem_ack = 0, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0] mem_be;
  logic [31:0] mem [0:1023];
  int total = 0, bad = 0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  rx_ring_engine #(.MIN_FRAME(64), .MAX_FRAME(100)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  assign mem_rdata = mem[mem_addr[11:2]];

  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && mem_ack && mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
    end
  end

  function automatic logic [7:0] mbyte(input int a);
    return mem[a[11:2]][8*a[1:0] +: 8];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic send_frame(input int len, input int seed, input logic err);
    int i = 0;
    while (i < len) begin
      @(negedge clk);
      rx_valid = 1; rx_data = 8'(seed + i);
      rx_sof = (i == 0); rx_eof = (i == len - 1); rx_err = err && (i == len - 1);
      #1 if (rx_ready) i++;
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 1024; w++) mem[w] = 32'hEEEE_EEEE;
    for (int k = 0; k < 4; k++) mem[(BASE + 16*k) >> 2] = 32'h400 + 32'h100 * k;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "mem_req in reset", {31'b0, mem_req}, 0);
    rst_n = 1;
    reg_read(3'd0, rd); check("R1", "irq status", rd, 0);
    reg_read(3'd5, rd); check("R1", "hw pointer", rd, 0);
    reg_read(3'd6, rd); check("R1", "capture", rd, 0);
    reg_read(3'd3, rd); check("R1", "ring start", rd, 0);

    reg_write(3'd3, BASE);
    reg_write(3'd4, LAST);
    reg_write(3'd7, BASE + 16);
    reg_write(3'd1, 32'h2);
    reg_write(3'd2, 32'h1);
    reg_read(3'd4, rd); check("R9", "last offset readback", rd, LAST);
    reg_read(3'd1, rd); check("R9", "dma ctrl readback", rd, 2);
    reg_read(3'd5, rd); check("R5", "hw ptr loaded by start write", rd, BASE);

    for (int k = 0; k < NV; k++) begin
      int len; int d; int ba; logic ok;
      len = int'(VEC[k][55:40]);
      d = BASE + 16 * (k % 4);
      ba = 32'h400 + 32'h100 * (k % 4);
      send_frame(len, 16 * k, VEC[k][32]);
      ok = 1;
      for (int i = 0; i < len; i++) if (mbyte(ba + i) !== 8'(16 * k + i)) ok = 0;
      check("R3", "payload bytes", {31'b0, ok}, 1);
      check("R3", "guard byte after payload", {24'b0, mbyte(ba + len)}, 32'hEE);
      check("R4", "length field", {16'b0, mem[(d + 8) >> 2][15:0]}, {16'b0, VEC[k][31:16]});
      check("R4", "mac status", {16'b0, mem[(d + 8) >> 2][31:16]}, {24'b0, VEC[k][15:8]});
      check("R4", "dma status byte", {24'b0, mbyte(d + 12)}, 1);
      reg_read(3'd0, rd); check("R7", "irq bits", rd, {24'b0, VEC[k][7:0]});
      reg_read(3'd6, rd); check("R8", "captured pointer", rd, BASE + 16 * ((k + 1) % 4));
      reg_write(3'd7, BASE + 16 * ((k + 2) % 4));
    end

    // R2: receive enable off
    mem[(BASE + 40) >> 2] = 32'hDEAD_BEEF;
    reg_write(3'd2, 32'h0);
    send_frame(64, 7, 0);
    reg_read(3'd5, rd); check("R2", "hw ptr with rx disabled", rd, BASE + 32);
    reg_read(3'd0, rd); check("R2", "irq with rx disabled", rd, 0);
    check("R2", "descriptor untouched", mem[(BASE + 40) >> 2], 32'hDEAD_BEEF);
    // R2: DMA enable off
    reg_write(3'd2, 32'h1);
    reg_write(3'd1, 32'h0);
    send_frame(64, 9, 0);
    reg_read(3'd5, rd); check("R2", "hw ptr with dma disabled", rd, BASE + 32);
    check("R2", "descriptor untouched dma off", mem[(BASE + 40) >> 2], 32'hDEAD_BEEF);
    reg_write(3'd1, 32'h2);

    // fill desc 2, then ring is full (hw == sw)
    send_frame(64, 3, 0);
    check("R4", "length after re-enable", {16'b0, mem[(BASE + 40) >> 2][15:0]}, 67);
    reg_read(3'd0, rd); check("R7", "irq good frame", rd, 3);
    mem[(BASE + 56) >> 2] = 32'hCAFE_F00D;
    send_frame(64, 5, 0);
    reg_read(3'd0, rd); check("R6", "empty irq on full ring", rd, 32'h20);
    reg_read(3'd5, rd); check("R6", "hw ptr held at sw ptr", rd, BASE + 48);
    check("R6", "sw descriptor not filled", mem[(BASE + 56) >> 2], 32'hCAFE_F00D);
    reg_read(3'd0, rd); check("R8", "read clears irq", rd, 0);
    check("R8", "irq line low", {31'b0, irq}, 0);

    reg_write(3'd3, 32'h200);
    reg_read(3'd5, rd); check("R5", "hw ptr reloaded", rd, 32'h200);
    reg_read(3'd7, rd); check("R9", "sw ptr readback", rd, BASE + 48);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule